// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address. It picks one of four 16-bit segment registers, appends four zero bits to it and adds the offset. Segments start on 16-byte boundaries, so a segment register holds a start address with its lowest hex digit left off. The sum is truncated to 20 bits, which gives a 1 MB address space that wraps around.

Each request names an access kind. The kind picks the default segment: instruction fetch uses the code segment, ordinary data uses the data segment, stack uses the stack segment, and a string destination uses the extra segment. The offset comes with the request and stands for the matching pointer (IP, SP/BP, DI or a data offset). An optional override, qualified by a valid bit, replaces the default segment for every kind except instruction fetch.

A request enters through a valid/ready handshake and goes out on a byte-wide memory request port. A byte access produces one byte cycle. A word access produces two byte cycles in little-endian order: the low byte at address A, then the high byte at A+1. The segment registers are loaded through a synchronous write port that has its own register select.

Top module: `seg_addr_gen`

The sequencer has three states, `ST_IDLE`, `ST_LOW` and `ST_HIGH`, and five transitions:
- **accept** (`ST_IDLE`→`ST_LOW`): taken when `req_valid` is high while the block is idle.
- **byte done** (`ST_LOW`→`ST_IDLE`): taken when a byte access completes its single cycle.
- **split** (`ST_LOW`→`ST_HIGH`): taken when the low byte of a word access completes.
- **word done** (`ST_HIGH`→`ST_IDLE`): taken when the high byte completes.
- **stall**: any state with an outstanding byte cycle stays where it is while `mem_ready` is low.

## Requirements
- R1: After reset, all four segment registers hold 0000H, `req_ready` is 1 and `mem_valid` is 0.
- R2: The physical address is (segment × 16 + offset) modulo 2^20. For example, 038EH:0032H gives 03912H and FFFFH:0020H gives 00010H.
- R3: Without an override, `req_kind` selects the segment: 00 = fetch uses CS, 01 = data uses DS, 10 = stack uses SS, 11 = string destination uses ES.
- R4: When `ovr_valid` is 1, `ovr_seg` selects the segment for kinds 01, 10 and 11, using the codes 00 = ES, 01 = CS, 10 = SS, 11 = DS. For kind 00 the override has no effect.
- R5: When `seg_we` is 1, the register coded by `seg_wsel` (same codes as R4) takes `seg_wdata` at the clock edge. A request accepted at that same edge still uses the old value.
- R6: A byte request (`req_word` = 0) produces exactly one byte cycle, with `mem_hi` = 0.
- R7: A word request produces two byte cycles. The first is at address A with `mem_hi` = 0. The second is at (A+1) modulo 2^20 with `mem_hi` = 1, so FFFFFH is followed by 00000H.
- R8: A request is accepted on a clock edge where both `req_valid` and `req_ready` are 1. `req_ready` is 1 only when no byte cycle is pending. The first byte cycle is presented in the cycle after acceptance. `req_ready` returns to 1 in the cycle after the last byte cycle completes.
- R9: A byte cycle completes on a clock edge where both `mem_valid` and `mem_ready` are 1. Until it completes, `mem_addr` and `mem_hi` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write (00 ES, 01 CS, 10 SS, 11 DS) |
| seg_wdata | input | 16 | Value to write into the segment register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | Access kind (00 fetch, 01 data, 10 stack, 11 string destination) |
| req_ofs | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| ovr_valid | input | 1 | Segment override valid |
| ovr_seg | input | 2 | Segment to use when the override is valid |
| mem_valid | output | 1 | Byte cycle present |
| mem_ready | input | 1 | Memory takes the byte cycle |
| mem_addr | output | 20 | Physical byte address |
| mem_hi | output | 1 | 1 = high byte of a word |

## Verification
The checker examines the handshake on every cycle. It confirms that `req_ready` and `mem_valid` are never high together. It confirms that an accepted request shows a low-byte cycle on the next cycle. It confirms that a stalled byte cycle keeps its address and byte flag. It confirms that a high-byte cycle follows its low byte at the wrapped next address and is the last cycle of its request. Three things need the scoreboard's scenarios: the address arithmetic including 1 MB wraparound, the default-segment choice for each kind, and whether an override is applied or ignored. The same holds for the rule that a write landing at the acceptance edge is not yet visible, because those depend on register contents that only a model of the writes can predict.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W   = 16;
    localparam int OFS_W   = 16;
    localparam int PADDR_W = 20;
    localparam int PARA_SH = 4;
    localparam int NSEG    = 4;
    localparam int SEL_W   = $clog2(NSEG);

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_t;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_t;

    function automatic seg_id_t default_seg(acc_kind_t kind);
        seg_id_t s;
        unique case (kind)
            ACC_FETCH:  s = SEG_CS;
            ACC_DATA:   s = SEG_DS;
            ACC_STACK:  s = SEG_SS;
            ACC_STRDST: s = SEG_ES;
            default:    s = SEG_DS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int W  = SEG_W,
    parameter int N  = NSEG,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] rsel,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (wsel == SW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata = regs[rsel];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_addr_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_seg,
    output logic [1:0] sel
);

    acc_kind_t k;
    seg_id_t   dflt;

    always_comb begin
        k    = acc_kind_t'(kind);
        dflt = default_seg(k);
        if (ovr_valid && (k != ACC_FETCH)) begin
            sel = ovr_seg;
        end else begin
            sel = dflt;
        end
    end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFS_W,
    parameter int AW = PADDR_W,
    parameter int SH = PARA_SH
) (
    input  logic [SW-1:0] seg,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] paddr
);

    logic [AW-1:0] base;
    logic [AW-1:0] disp;

    always_comb begin
        base  = AW'({seg, {SH{1'b0}}});
        disp  = AW'(ofs);
        paddr = base + disp;
    end

endmodule

// File: rtl/seg_byte_seq.sv
module seg_byte_seq
    import seg_addr_pkg::*;
#(
    parameter int AW = PADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_hi
);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          word_q;
    logic          accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOW;
            ST_LOW:  if (mem_ready) state_d = word_q ? ST_HIGH : ST_IDLE;
            ST_HIGH: if (mem_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            word_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr;
                word_q <= req_word;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_hi    = 1'b0;
        mem_addr  = addr_q;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOW:  mem_valid = 1'b1;
            ST_HIGH: begin
                mem_valid = 1'b1;
                mem_hi    = 1'b1;
                mem_addr  = addr_q + AW'(1);
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEGW = SEG_W,
    parameter int OFSW = OFS_W,
    parameter int AW   = PADDR_W,
    parameter int SH   = PARA_SH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seg_we,
    input  logic [1:0]      seg_wsel,
    input  logic [SEGW-1:0] seg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [OFSW-1:0] req_ofs,
    input  logic            req_word,
    input  logic            ovr_valid,
    input  logic [1:0]      ovr_seg,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_hi
);

    logic [1:0]      sel;
    logic [SEGW-1:0] seg_val;
    logic [AW-1:0]   paddr;

    seg_pick u_pick (
        .kind      (req_kind),
        .ovr_valid (ovr_valid),
        .ovr_seg   (ovr_seg),
        .sel       (sel)
    );

    seg_regfile #(.W(SEGW), .N(NSEG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_wsel),
        .wdata (seg_wdata),
        .rsel  (sel),
        .rdata (seg_val)
    );

    seg_addr_calc #(.SW(SEGW), .OW(OFSW), .AW(AW), .SH(SH)) u_calc (
        .seg   (seg_val),
        .ofs   (req_ofs),
        .paddr (paddr)
    );

    seg_byte_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_word  (req_word),
        .req_addr  (paddr),
        .req_ready (req_ready),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_hi    (mem_hi)
    );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_hi
);

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_valid)); // R8

    AST_ACCEPT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_valid && !mem_hi)); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_hi))); // R9

    AST_HIGH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_hi) |=>
            (!mem_valid || (mem_hi && (mem_addr == $past(mem_addr) + AW'(1))))); // R7

    AST_HIGH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_hi) |=> (!mem_valid && req_ready)); // R7

    AST_BYTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_hi) |=> (mem_valid || req_ready)); // R6

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_hi    (mem_hi)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wsel = 2'd0;
    logic [15:0] seg_wdata = 16'h0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_ofs = 16'h0;
    logic        req_word = 1'b0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_seg = 2'd0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [19:0] mem_addr;
    logic        mem_hi;

    always #2.5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
        .seg_wdata(seg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_ofs(req_ofs), .req_word(req_word),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_hi(mem_hi)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] model_seg [4];
    logic [19:0] exp_addr [$];
    logic        exp_hi [$];
    string       exp_tag [$];

    // model segment codes: 0 ES, 1 CS, 2 SS, 3 DS
    function automatic logic [1:0] pick(logic [1:0] kind, logic ov, logic [1:0] os);
        logic [1:0] d;
        case (kind)
            2'd0: d = 2'd1;
            2'd1: d = 2'd3;
            2'd2: d = 2'd2;
            default: d = 2'd0;
        endcase
        if (ov && kind != 2'd0) d = os;
        return d;
    endfunction

    function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic seg_write(logic [1:0] sel, logic [15:0] val);
        @(negedge clk);
        seg_we = 1'b1; seg_wsel = sel; seg_wdata = val;
        @(posedge clk); #1;
        seg_we = 1'b0;
        model_seg[sel] = val;
    endtask

    // driver: waits for idle, pushes expected byte cycles, presents request
    task automatic issue(string tag, logic [1:0] kind, logic [15:0] ofs, logic word,
                         logic ov, logic [1:0] os,
                         logic wr, logic [1:0] wsel, logic [15:0] wval);
        logic [19:0] a;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        a = phys(model_seg[pick(kind, ov, os)], ofs);
        exp_addr.push_back(a); exp_hi.push_back(1'b0); exp_tag.push_back(tag);
        if (word) begin
            exp_addr.push_back(a + 20'd1); exp_hi.push_back(1'b1); exp_tag.push_back(tag);
        end
        req_valid = 1'b1; req_kind = kind; req_ofs = ofs; req_word = word;
        ovr_valid = ov; ovr_seg = os;
        seg_we = wr; seg_wsel = wsel; seg_wdata = wval;
        @(posedge clk); #1;
        req_valid = 1'b0; ovr_valid = 1'b0; seg_we = 1'b0;
        if (wr) model_seg[wsel] = wval;
    endtask

    // memory ready pattern with stalls
    int stall_cnt = 0;
    always @(posedge clk) begin
        #1;
        stall_cnt <= stall_cnt + 1;
        mem_ready <= (stall_cnt % 3) != 2;
    end

    // monitor: handshake rules and scoreboard compare
    logic        prev_stall = 1'b0;
    logic [19:0] prev_addr = '0;
    logic        prev_hi = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_valid) begin
                check("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
                if (prev_stall)
                    check("R9 stalled cycle held", {11'd0, mem_hi, mem_addr},
                          {11'd0, prev_hi, prev_addr});
                if (mem_ready) begin
                    if (exp_addr.size() == 0) begin
                        check("R8 unexpected byte cycle", {12'd0, mem_addr}, 32'hFFFFFFFF);
                    end else begin
                        check({exp_tag[0], " addr"}, {12'd0, mem_addr}, {12'd0, exp_addr[0]});
                        check({exp_tag[0], " hi"}, {31'd0, mem_hi}, {31'd0, exp_hi[0]});
                        void'(exp_addr.pop_front());
                        void'(exp_hi.pop_front());
                        void'(exp_tag.pop_front());
                    end
                end
            end
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            prev_hi    = mem_hi;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_seg[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 no cycle after reset", {31'd0, mem_valid}, 32'd0);
        // R1: every segment reads zero
        issue("R1 zero DS", 2'd1, 16'h0005, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R1 zero ES", 2'd3, 16'h0007, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        seg_write(2'd1, 16'hF000);
        seg_write(2'd3, 16'h038E);
        seg_write(2'd2, 16'h2000);
        seg_write(2'd0, 16'h1234);
        issue("R3 fetch CS", 2'd0, 16'hFFF0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R2 data 038E:0032", 2'd1, 16'h0032, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R3 stack SS", 2'd2, 16'h0100, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R3 string ES", 2'd3, 16'h0010, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R6 byte", 2'd1, 16'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R7 word", 2'd2, 16'h00FE, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R4 data override ES", 2'd1, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R4 stack override CS", 2'd2, 16'h0004, 1'b1, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0);
        issue("R4 fetch override ignored", 2'd0, 16'h0002, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0);
        seg_write(2'd3, 16'hFFFF);
        issue("R2 wrap sum", 2'd1, 16'h0020, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        issue("R7 word wrap", 2'd1, 16'h000F, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        // R5: write at the acceptance edge is not yet seen, the next request sees it
        issue("R5 same edge old", 2'd1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 16'h0500);
        issue("R5 new value", 2'd1, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        // R5: write during a busy word cycle, then use it
        issue("R7 word busy", 2'd3, 16'h0001, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        seg_write(2'd0, 16'hABCD);
        issue("R5 written while busy", 2'd3, 16'h0003, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
        for (int i = 0; i < 200 && exp_addr.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 all cycles delivered", exp_addr.size(), 32'd0);
        check("R8 ready at end", {31'd0, req_ready}, 32'd1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule